// File: doc/BRIEF.md
# Program Trace Capture Buffer

The block sits beside a processor and records its program flow. Each clock it looks at the 3-bit instruction-flow status code, the 2-bit queue-flush status and the external bus. A bus cycle that carries the program-trace attribute becomes one stored entry while capture is active. An entry holds the flow code, the flush code and the cycle's address. A flow code of 3'b011 is the synchronization marker, and it opens or closes the capture window.

There are two capture styles. In back-trace mode the unit starts storing right away after reset release, or after a re-arm, and stops at the first marker. The buffer then holds the flow that ran before the event. In window mode the unit waits for a marker, stores entries, and stops at the next marker. A cyclic option keeps the newest entries by overwriting the oldest ones. Without it, capture ends when the buffer fills. Once capture has stopped, a host reads entries through an index port. Index 0 is always the oldest entry still held.

The controller has four states. IDLE samples the configuration and lasts one cycle. SEEK waits for the opening marker. RECORD stores entries. HOLD keeps the result for reading. Its transitions are:
- IDLE to SEEK in window mode, or IDLE to RECORD in back-trace mode.
- SEEK to RECORD on a marker.
- RECORD to HOLD on a marker, or when a non-cyclic buffer is full.
- Any state other than IDLE goes back to IDLE on `arm`.

Top module: `trace_capture`

## Requirements
- R1: After reset, `done`, `capturing`, `full` and `wrapped` are low and `entry_count` is 0.
- R2: A flow code of 3'b011 is the marker. In window mode nothing is stored until a marker has been seen. Storing starts the cycle after the marker, and the marker cycle itself is never stored.
- R3: While recording, a marker stops capture. `done` rises the cycle after the marker and stays high until `arm`.
- R4: In back-trace mode no marker is needed to start. Storing is live from the second clock after reset release or after `arm`, because the first of those clocks is the IDLE configuration cycle.
- R5: An entry is stored only in a recording cycle where `addr_strobe` and `trace_attr` are both high and the flow code is not the marker. It holds that cycle's flow code, flush code and address.
- R6: With the cyclic option off, storing stops once `DEPTH` entries are held. `full` is then high, `done` rises on the next cycle, and `entry_count` never goes above `DEPTH`.
- R7: With the cyclic option on, storing continues past `DEPTH` and overwrites the oldest entry. `entry_count` stays at `DEPTH`. `wrapped` rises with the first overwrite and not before.
- R8: `rd_idx` = k returns the k-th oldest held entry on `rd_flow`, `rd_flush` and `rd_addr`.
- R9: `cfg_window` and `cfg_cyclic` are sampled only in IDLE. Changing them during capture has no effect.
- R10: `arm` in any state other than IDLE returns the unit to IDLE on the next clock. This clears `entry_count`, `full`, `wrapped` and `done` and restarts capture in the sampled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_window | input | 1 | 1 = window mode, 0 = back-trace mode (sampled in IDLE) |
| cfg_cyclic | input | 1 | 1 = overwrite oldest entries when full (sampled in IDLE) |
| arm | input | 1 | Restart capture |
| flow_code | input | 3 | Instruction-flow status code, 3'b011 = marker |
| flush_code | input | 2 | Queue-flush status |
| bus_addr | input | 32 | Bus cycle address |
| addr_strobe | input | 1 | Address valid this cycle |
| trace_attr | input | 1 | Bus cycle carries the program-trace attribute |
| rd_idx | input | $clog2(DEPTH) | Read index, 0 = oldest |
| rd_flow | output | 3 | Flow code of the indexed entry |
| rd_flush | output | 2 | Flush code of the indexed entry |
| rd_addr | output | 32 | Address of the indexed entry |
| entry_count | output | $clog2(DEPTH+1) | Entries held |
| done | output | 1 | Capture finished (HOLD) |
| capturing | output | 1 | Recording active (RECORD) |
| full | output | 1 | Buffer holds DEPTH entries |
| wrapped | output | 1 | An overwrite has occurred |

## Verification
The assertions guard properties that must hold on every cycle:
- SEEK never leaves without a marker.
- A marker in RECORD always reaches HOLD.
- HOLD persists until `arm`, and `arm` always returns to IDLE.
- The sampled cyclic setting is frozen outside IDLE.
- The count stays bounded and is frozen while a non-cyclic buffer is full.
- `wrapped` rises only on an overwrite of a full buffer.

The bench scenarios are what show the contents and ordering of the stored entries: which cycles were filtered out, the oldest-first readback after a wrap, the back-trace start timing, and the fact that configuration changes during capture have no effect.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int FLOW_W  = 3;
    localparam int FLUSH_W = 2;
    localparam int ADDR_W  = 32;
    localparam logic [FLOW_W-1:0] SYNC_CODE = 3'b011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_RECORD,
        ST_HOLD
    } cap_state_t;

    typedef struct packed {
        logic [FLOW_W-1:0]  flow;
        logic [FLUSH_W-1:0] flush;
        logic [ADDR_W-1:0]  addr;
    } trace_entry_t;
endpackage

// File: rtl/trace_fsm.sv
module trace_fsm
    import trace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_window,
    input  logic              cfg_cyclic,
    input  logic              arm,
    input  logic [FLOW_W-1:0] flow_code,
    input  logic              buf_full,
    output cap_state_t        state,
    output logic              cyc_mode,
    output logic              rec_win,
    output logic              clear
);
    cap_state_t state_q, state_d;
    logic       cyc_q;
    logic       is_sync;

    assign is_sync = (flow_code == SYNC_CODE);

    // state register and configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cyc_q <= cfg_cyclic;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cfg_window ? ST_SEEK : ST_RECORD;
            ST_SEEK: begin
                if (arm)          state_d = ST_IDLE;
                else if (is_sync) state_d = ST_RECORD;
            end
            ST_RECORD: begin
                if (arm)                      state_d = ST_IDLE;
                else if (is_sync)             state_d = ST_HOLD;
                else if (buf_full && !cyc_q)  state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (arm) state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state    = state_q;
        cyc_mode = cyc_q;
        rec_win  = (state_q == ST_RECORD) && !arm;
        clear    = (state_q != ST_IDLE) && arm;
    end

    assert_seek_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEEK && !is_sync && !arm) |=> state_q == ST_SEEK);

    assert_sync_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECORD && is_sync && !arm) |=> state_q == ST_HOLD);

    assert_hold_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !arm) |=> state_q == ST_HOLD);

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cyc_q));

    assert_arm_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && arm) |=> state_q == ST_IDLE);
endmodule

// File: rtl/trace_store.sv
module trace_store
    import trace_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               rec_win,
    input  logic               cyc_mode,
    input  logic [FLOW_W-1:0]  flow_code,
    input  logic [FLUSH_W-1:0] flush_code,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               addr_strobe,
    input  logic               trace_attr,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CNT_W-1:0]   count,
    output logic               full,
    output logic               wrapped,
    output trace_entry_t       rd_entry
);
    trace_entry_t     mem [DEPTH];
    logic [IDX_W-1:0] wptr;
    logic [CNT_W-1:0] count_q;
    logic             wrapped_q;
    logic             is_full;
    logic             wr;
    logic [IDX_W:0]   rd_sum;
    logic [IDX_W-1:0] rd_phys;
    logic [IDX_W-1:0] base;

    assign is_full = (count_q == CNT_W'(DEPTH));
    assign wr = rec_win && addr_strobe && trace_attr &&
                (flow_code != SYNC_CODE) && !(is_full && !cyc_mode);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr      <= '0;
            count_q   <= '0;
            wrapped_q <= 1'b0;
        end else if (wr) begin
            wptr <= (wptr == IDX_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (is_full) wrapped_q <= 1'b1;
            else         count_q   <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[wptr] <= '{flow: flow_code, flush: flush_code, addr: bus_addr};
        end
    end

    always_comb begin
        base   = wrapped_q ? wptr : '0;
        rd_sum = {1'b0, base} + {1'b0, rd_idx};
        if (rd_sum >= (IDX_W + 1)'(DEPTH)) rd_phys = IDX_W'(rd_sum - (IDX_W + 1)'(DEPTH));
        else                               rd_phys = rd_sum[IDX_W-1:0];
        rd_entry = mem[rd_phys];
        count    = count_q;
        full     = is_full;
        wrapped  = wrapped_q;
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    assert_full_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && !cyc_mode && !clear) |=> $stable(count_q));

    assert_wrap_on_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrapped_q) |-> ($past(count_q) == CNT_W'(DEPTH) && $past(cyc_mode)));
endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_window,
    input  logic               cfg_cyclic,
    input  logic               arm,
    input  logic [FLOW_W-1:0]  flow_code,
    input  logic [FLUSH_W-1:0] flush_code,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               addr_strobe,
    input  logic               trace_attr,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FLOW_W-1:0]  rd_flow,
    output logic [FLUSH_W-1:0] rd_flush,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   entry_count,
    output logic               done,
    output logic               capturing,
    output logic               full,
    output logic               wrapped
);
    cap_state_t   state;
    logic         cyc_mode;
    logic         rec_win;
    logic         clear;
    logic         buf_full;
    trace_entry_t rd_entry;

    trace_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_window (cfg_window),
        .cfg_cyclic (cfg_cyclic),
        .arm        (arm),
        .flow_code  (flow_code),
        .buf_full   (buf_full),
        .state      (state),
        .cyc_mode   (cyc_mode),
        .rec_win    (rec_win),
        .clear      (clear)
    );

    trace_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .rec_win     (rec_win),
        .cyc_mode    (cyc_mode),
        .flow_code   (flow_code),
        .flush_code  (flush_code),
        .bus_addr    (bus_addr),
        .addr_strobe (addr_strobe),
        .trace_attr  (trace_attr),
        .rd_idx      (rd_idx),
        .count       (entry_count),
        .full        (buf_full),
        .wrapped     (wrapped),
        .rd_entry    (rd_entry)
    );

    always_comb begin
        rd_flow   = rd_entry.flow;
        rd_flush  = rd_entry.flush;
        rd_addr   = rd_entry.addr;
        done      = (state == ST_HOLD);
        capturing = (state == ST_RECORD);
        full      = buf_full;
    end
endmodule

// File: tb/trace_capture_test.sv
module trace_capture_test;
    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_window = 1'b0;
    logic             cfg_cyclic = 1'b0;
    logic             arm = 1'b0;
    logic [2:0]       flow_code = 3'd0;
    logic [1:0]       flush_code = 2'd0;
    logic [31:0]      bus_addr = 32'd0;
    logic             addr_strobe = 1'b0;
    logic             trace_attr = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [2:0]       rd_flow;
    logic [1:0]       rd_flush;
    logic [31:0]      rd_addr;
    logic [CNT_W-1:0] entry_count;
    logic             done, capturing, full, wrapped;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trace_capture #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .cfg_cyclic(cfg_cyclic),
        .arm(arm), .flow_code(flow_code), .flush_code(flush_code), .bus_addr(bus_addr),
        .addr_strobe(addr_strobe), .trace_attr(trace_attr), .rd_idx(rd_idx),
        .rd_flow(rd_flow), .rd_flush(rd_flush), .rd_addr(rd_addr),
        .entry_count(entry_count), .done(done), .capturing(capturing),
        .full(full), .wrapped(wrapped)
    );

    typedef struct packed {
        logic [2:0]  flow;
        logic [1:0]  flush;
        logic [31:0] addr;
        logic        strobe;
        logic        attr;
        logic        keep;   // expected to be stored
    } vec_t;

    // window-mode run, marker = 3'b011
    localparam vec_t VEC [8] = '{
        '{flow: 3'd0, flush: 2'd0, addr: 32'h0000_00A0, strobe: 1'b1, attr: 1'b1, keep: 1'b0},
        '{flow: 3'd3, flush: 2'd0, addr: 32'h0000_00A4, strobe: 1'b1, attr: 1'b1, keep: 1'b0},
        '{flow: 3'd1, flush: 2'd2, addr: 32'h0000_0100, strobe: 1'b1, attr: 1'b1, keep: 1'b1},
        '{flow: 3'd2, flush: 2'd0, addr: 32'h0000_0104, strobe: 1'b1, attr: 1'b0, keep: 1'b0},
        '{flow: 3'd0, flush: 2'd1, addr: 32'h0000_0108, strobe: 1'b0, attr: 1'b1, keep: 1'b0},
        '{flow: 3'd4, flush: 2'd3, addr: 32'h0000_010C, strobe: 1'b1, attr: 1'b1, keep: 1'b1},
        '{flow: 3'd3, flush: 2'd1, addr: 32'h0000_0110, strobe: 1'b1, attr: 1'b1, keep: 1'b0},
        '{flow: 3'd1, flush: 2'd1, addr: 32'h0000_0114, strobe: 1'b1, attr: 1'b1, keep: 1'b0}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] f, input logic [1:0] fl, input logic [31:0] a,
                       input logic s, input logic t);
        flow_code = f; flush_code = fl; bus_addr = a; addr_strobe = s; trace_attr = t;
        @(negedge clk);
    endtask

    task automatic idle_cyc();
        cyc(3'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        idle_cyc();
        arm = 1'b0;
    endtask

    task automatic read_at(input int k);
        rd_idx = IDX_W'(k);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_addr [8];
        logic [2:0]  exp_flow [8];
        logic [1:0]  exp_flush [8];
        int n_exp;

        // R1 reset state
        cfg_window = 1'b1;
        cfg_cyclic = 1'b0;
        @(negedge clk); @(negedge clk);
        check(done == 0 && capturing == 0 && full == 0 && wrapped == 0 && entry_count == 0,
              "R1", {done, capturing, full, wrapped, 4'(entry_count)}, 0);
        rst_n = 1'b1;
        idle_cyc();   // IDLE configuration cycle

        // table walk: window mode R2 R3 R5
        n_exp = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(VEC[i].flow, VEC[i].flush, VEC[i].addr, VEC[i].strobe, VEC[i].attr);
            if (VEC[i].keep) begin
                exp_addr[n_exp]  = VEC[i].addr;
                exp_flow[n_exp]  = VEC[i].flow;
                exp_flush[n_exp] = VEC[i].flush;
                n_exp++;
            end
            if (i == 0) check(entry_count == 0 && capturing == 0, "R2 no store before marker",
                              entry_count, 0);
            if (i == 1) check(capturing == 1 && entry_count == 0, "R2 marker not stored",
                              {capturing, 4'(entry_count)}, 5'h10);
        end
        check(done == 1, "R3 second marker ends window", done, 1);
        check(entry_count == CNT_W'(n_exp), "R5 filtered count", entry_count, n_exp);
        for (int k = 0; k < n_exp; k++) begin
            read_at(k);
            check(rd_addr == exp_addr[k] && rd_flow == exp_flow[k] && rd_flush == exp_flush[k],
                  "R5 R8 entry content", {rd_flow, rd_flush, rd_addr},
                  {exp_flow[k], exp_flush[k], exp_addr[k]});
        end
        idle_cyc(); idle_cyc();
        check(done == 1, "R3 done held", done, 1);

        // R10 arm clears, R4 back-trace start timing
        cfg_window = 1'b0;
        do_arm();
        check(done == 0 && entry_count == 0 && capturing == 0, "R10 arm clears",
              {done, 4'(entry_count)}, 0);
        cyc(3'd1, 2'd0, 32'h0000_0500, 1'b1, 1'b1);   // IDLE cycle: not stored
        check(entry_count == 0 && capturing == 1, "R4 config cycle not stored", entry_count, 0);
        cyc(3'd2, 2'd1, 32'h0000_0504, 1'b1, 1'b1);
        cyc(3'd1, 2'd0, 32'h0000_0508, 1'b1, 1'b1);
        check(entry_count == 2, "R4 back-trace stores without marker", entry_count, 2);
        cyc(3'd3, 2'd0, 32'h0000_050C, 1'b1, 1'b1);
        check(done == 1 && entry_count == 2, "R4 marker ends back-trace", entry_count, 2);
        read_at(0);
        check(rd_addr == 32'h0000_0504, "R8 oldest first", rd_addr, 32'h504);

        // R6 non-cyclic fill
        do_arm();
        idle_cyc();
        for (int i = 0; i < DEPTH + 2; i++) cyc(3'd1, 2'd0, 32'h1000 + 32'(i), 1'b1, 1'b1);
        check(full == 1 && done == 1 && entry_count == CNT_W'(DEPTH), "R6 stops at depth",
              entry_count, DEPTH);
        check(wrapped == 0, "R6 no overwrite", wrapped, 0);
        read_at(DEPTH - 1);
        check(rd_addr == 32'h1000 + 32'(DEPTH - 1), "R6 last kept entry", rd_addr,
              32'h1000 + DEPTH - 1);

        // R7 cyclic, R9 config frozen during capture
        cfg_cyclic = 1'b1;
        do_arm();
        idle_cyc();   // cyclic option sampled here
        cyc(3'd1, 2'd0, 32'h2000, 1'b1, 1'b1);
        cfg_cyclic = 1'b0;   // must be ignored (R9)
        cfg_window = 1'b1;
        for (int i = 1; i < DEPTH; i++) cyc(3'd1, 2'd0, 32'h2000 + 32'(i), 1'b1, 1'b1);
        check(entry_count == CNT_W'(DEPTH) && wrapped == 0, "R7 no wrap before overwrite",
              wrapped, 0);
        idle_cyc();
        check(done == 0 && capturing == 1, "R9 cyclic setting kept", done, 0);
        for (int i = DEPTH; i < DEPTH + 3; i++) cyc(3'd2, 2'd1, 32'h2000 + 32'(i), 1'b1, 1'b1);
        check(wrapped == 1 && entry_count == CNT_W'(DEPTH), "R7 wrap on overwrite",
              wrapped, 1);
        cyc(3'd3, 2'd0, 32'h0, 1'b1, 1'b1);
        check(done == 1, "R3 marker stops cyclic", done, 1);
        read_at(0);
        check(rd_addr == 32'h2003, "R7 R8 oldest after wrap", rd_addr, 32'h2003);
        read_at(DEPTH - 1);
        check(rd_addr == 32'h2000 + 32'(DEPTH + 2) && rd_flow == 3'd2, "R8 newest last",
              rd_addr, 32'h2000 + DEPTH + 2);

        // R10 arm in window mode restarts waiting
        cfg_cyclic = 1'b0;
        do_arm();
        idle_cyc();
        cyc(3'd1, 2'd0, 32'h3000, 1'b1, 1'b1);
        check(entry_count == 0 && done == 0 && wrapped == 0, "R10 window restart waits",
              entry_count, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule